// File: doc/BRIEF.md
# Selectable Input Debounce and Glitch Filter

This block cleans up one raw digital line, such as an encoder phase or index signal, before it reaches the counters. The line is brought into the clock domain through a two-stage synchronizer and then passes through a filter. The filter has two behaviours. In debounce mode it accepts a new level only after the line has held that level for the selected number of clock ticks. In glitch-detect mode it forwards the first edge at once and then ignores the line for the selected time.

A 4-bit select chooses one of sixteen filter windows. At a 48 MHz clock these run from 500 ns (24 ticks) up to 25 ms (1,200,000 ticks), in roughly geometric steps. A polarity input decides which edge direction is filtered. Edges in the other direction reach the output without filtering.

Top module: `edge_qual_filter`

## Requirements
- R1: While `rst_ni` is low, `level_o` is 0 and no filter window is open.
- R2: The raw input is synchronized through two flops. A change that passes unfiltered appears on `level_o` on the third rising clock edge after the change on `raw_i`.
- R3: `time_sel_i` selects the window length N in clock ticks from a fixed table. Select 0 gives 24, select 1 gives 49, select 2 gives 101 and select 15 gives 1,200,000, with steps of about 2.06x in between.
- R4: In debounce mode (`mode_i`=0), a filtered-direction level is accepted once the synchronized input has shown it on N consecutive edges. For a step on `raw_i`, `level_o` changes on rising edge N+2.
- R5: In debounce mode, any return of the input to the current output level during the window restarts the window. A pulse shorter than N ticks never reaches `level_o`.
- R6: With `edge_pol_i`=1, rising transitions (0 to 1) are the filtered direction. With `edge_pol_i`=0, falling transitions (1 to 0) are. Transitions in the opposite direction pass with the latency given in R2.
- R7: In glitch mode (`mode_i`=1), a filtered-direction transition passes with the R2 latency and opens a hold of N ticks. During the hold `level_o` ignores the input. If the output changes on edge S, its next change can come no earlier than edge S+N.
- R8: The window length is captured when a window opens. A change of `time_sel_i` while a window is open does not alter that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Filter clock (48 MHz in the target system) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 1 | Unsynchronized raw input line |
| time_sel_i | input | 4 | Window length select (index into the tick table) |
| edge_pol_i | input | 1 | 1: rising edges filtered, 0: falling edges filtered |
| mode_i | input | 1 | 0: debounce, 1: glitch-detect |
| level_o | output | 1 | Filtered level |

## Verification
The properties assume that `mode_i` and `edge_pol_i` stay constant while a window is open. Under that assumption, each change of `level_o` can be traced to a single kind of decision: an unfiltered pass, a debounce acceptance or the start of a glitch hold. The stimulus sets mode, polarity and select only after a long idle stretch in which input and output agree, so no window is open at that time. The one exception is the test that changes `time_sel_i` during an open window on purpose, to show that the captured length is kept.

// File: rtl/edge_qual_filter_pkg.sv
package edge_qual_filter_pkg;

  typedef enum logic {
    FLT_DEBOUNCE = 1'b0,
    FLT_GLITCH   = 1'b1
  } flt_mode_e;

  // Window length in clock ticks for each select value (48 MHz reference).
  function automatic logic [20:0] window_ticks(input logic [3:0] sel);
    case (sel)
      4'd0:    window_ticks = 21'd24;
      4'd1:    window_ticks = 21'd49;
      4'd2:    window_ticks = 21'd101;
      4'd3:    window_ticks = 21'd208;
      4'd4:    window_ticks = 21'd428;
      4'd5:    window_ticks = 21'd881;
      4'd6:    window_ticks = 21'd1813;
      4'd7:    window_ticks = 21'd3731;
      4'd8:    window_ticks = 21'd7679;
      4'd9:    window_ticks = 21'd15803;
      4'd10:   window_ticks = 21'd32522;
      4'd11:   window_ticks = 21'd66930;
      4'd12:   window_ticks = 21'd137743;
      4'd13:   window_ticks = 21'd283474;
      4'd14:   window_ticks = 21'd583391;
      default: window_ticks = 21'd1200000;
    endcase
  endfunction

  // A new level is in the filtered direction when it equals the polarity
  // (rising -> new level 1 with pol 1, falling -> new level 0 with pol 0).
  function automatic logic is_qualified(input logic new_lvl, input logic pol);
    is_qualified = (new_lvl == pol);
  endfunction

endpackage

// File: rtl/eqf_sync.sv
module eqf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eqf_window.sv
module eqf_window #(
  parameter int CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             active_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign last_o   = active_q && (cnt_q == lim_q - CNT_W'(1));
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign lim_o    = lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else begin
      if (!active_q) lim_q <= lim_i;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          cnt_q    <= CNT_W'(1);
        end
      end else if (abort_i || last_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/edge_qual_filter.sv
module edge_qual_filter
  import edge_qual_filter_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 21,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [SEL_W-1:0] time_sel_i,
  input  logic             edge_pol_i,
  input  logic             mode_i,
  output logic             level_o
);
  localparam int TBL_SEL_W = 4;

  logic             sync_w;
  logic             level_q;
  logic             level_d;
  logic             mism_w;
  logic             qual_w;
  logic             glitch_w;
  logic             start_w;
  logic             abort_w;
  logic             pass_w;
  logic             accept_w;
  logic             win_active_w;
  logic             win_last_w;
  logic [CNT_W-1:0] win_cnt_w;
  logic [CNT_W-1:0] win_lim_w;
  logic [CNT_W-1:0] sel_lim_w;
  logic [TBL_SEL_W-1:0] sel_idx_w;
  flt_mode_e        mode_w;

  eqf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (sync_w)
  );

  assign sel_idx_w = TBL_SEL_W'(time_sel_i);
  assign sel_lim_w = CNT_W'(window_ticks(sel_idx_w));

  assign mode_w   = flt_mode_e'(mode_i);
  assign glitch_w = (mode_w == FLT_GLITCH);
  assign mism_w   = sync_w ^ level_q;
  assign qual_w   = is_qualified(sync_w, edge_pol_i);

  assign start_w  = !win_active_w && mism_w && qual_w;
  assign abort_w  = !glitch_w && win_active_w && !mism_w;
  assign pass_w   = !win_active_w && mism_w && (!qual_w || glitch_w);
  assign accept_w = !glitch_w && win_active_w && mism_w && win_last_w;

  eqf_window #(.CNT_W(CNT_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lim_i    (sel_lim_w),
    .start_i  (start_w),
    .abort_i  (abort_w),
    .active_o (win_active_w),
    .last_o   (win_last_w),
    .cnt_o    (win_cnt_w),
    .lim_o    (win_lim_w)
  );

  always_comb begin
    level_d = level_q;
    if (pass_w || accept_w) level_d = sync_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/edge_qual_filter_chk.sv
module edge_qual_filter_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             edge_pol_i,
  input logic             level_o,
  input logic             sync_w,
  input logic             win_active_w,
  input logic [CNT_W-1:0] win_cnt_w,
  input logic [CNT_W-1:0] win_lim_w
);
  // R1: no window open while in reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_idle_in_reset_R1: assert (!win_active_w && !level_o)
        else $error("window open or output high during reset");
    end
  end

  // R2: every output change takes the synchronized level
  assert_follows_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o) |-> level_o == $past(sync_w));

  // R4: a debounce change in the filtered direction closes an open window
  assert_debounce_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(level_o) && !$past(mode_i) && (level_o == $past(edge_pol_i)))
      |-> $past(win_active_w));

  // R7: the output is frozen while a glitch hold runs
  assert_glitch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(win_active_w) && $past(mode_i)) |-> $stable(level_o));

  // R3: the window count stays below its captured length
  assert_cnt_below_lim_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_active_w |-> (win_cnt_w < win_lim_w));

  // R8: the captured length does not move during a window
  assert_lim_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_active_w && $past(win_active_w)) |-> $stable(win_lim_w));
endmodule

bind edge_qual_filter edge_qual_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .edge_pol_i   (edge_pol_i),
  .level_o      (level_o),
  .sync_w       (sync_w),
  .win_active_w (win_active_w),
  .win_cnt_w    (win_cnt_w),
  .win_lim_w    (win_lim_w)
);

// File: tb/tb_edge_qual_filter.sv
module tb_edge_qual_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       pol = 1'b1;
  logic       mode = 1'b0;
  logic       lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_qual_filter dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .raw_i      (raw),
    .time_sel_i (sel),
    .edge_pol_i (pol),
    .mode_i     (mode),
    .level_o    (lvl)
  );

  // {mode, pol, sel, width, expected rise edge, expected fall edge}
  typedef struct packed {
    logic        m;
    logic        p;
    logic [3:0]  s;
    logic [15:0] w;
    logic [15:0] rise;
    logic [15:0] fall;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'd0, 16'd30,  16'd26,  16'd33},   // R4 R3 N=24
    '{1'b0, 1'b1, 4'd0, 16'd24,  16'd26,  16'd27},   // R4 exact N
    '{1'b0, 1'b1, 4'd0, 16'd23,  16'd0,   16'd0},    // R5 short pulse
    '{1'b0, 1'b1, 4'd1, 16'd60,  16'd51,  16'd63},   // R3 N=49
    '{1'b0, 1'b1, 4'd2, 16'd120, 16'd103, 16'd123},  // R3 N=101
    '{1'b0, 1'b1, 4'd2, 16'd100, 16'd0,   16'd0},    // R5 short pulse
    '{1'b0, 1'b0, 4'd0, 16'd5,   16'd3,   16'd31},   // R6 falling filtered
    '{1'b0, 1'b0, 4'd2, 16'd1,   16'd3,   16'd104},  // R6
    '{1'b1, 1'b1, 4'd0, 16'd2,   16'd3,   16'd27},   // R7 hold N=24
    '{1'b1, 1'b1, 4'd1, 16'd2,   16'd3,   16'd52},   // R7 hold N=49
    '{1'b1, 1'b0, 4'd0, 16'd10,  16'd3,   16'd13}    // R7 R6 opposite dir
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    raw = 1'b1;
    step(3);
    check("R1 reset level", int'(lvl), 0);
    rst_n = 1'b1;
    raw = 1'b0;
    step(5);
    check("R1 idle level", int'(lvl), 0);

    // Table-driven pulse vectors
    for (int v = 0; v < NV; v++) begin
      int rise_e;
      int fall_e;
      mode = VECS[v].m;
      pol  = VECS[v].p;
      sel  = VECS[v].s;
      rise_e = 0;
      fall_e = 0;
      raw = 1'b1;
      for (int k = 1; k <= 300; k++) begin
        step(1);
        if (k == int'(VECS[v].w)) raw = 1'b0;
        if (rise_e == 0 && lvl) rise_e = k;
        else if (rise_e != 0 && fall_e == 0 && !lvl) fall_e = k;
      end
      check($sformatf("R4/R5/R6/R7 vec%0d rise", v), rise_e, int'(VECS[v].rise));
      check($sformatf("R4/R5/R6/R7 vec%0d fall", v), fall_e, int'(VECS[v].fall));
    end

    // R2: unfiltered rising edge, three-edge latency
    mode = 1'b0; pol = 1'b0; sel = 4'd0;
    raw = 1'b1;
    step(2);
    check("R2 before latency", int'(lvl), 0);
    step(1);
    check("R2 at edge 3", int'(lvl), 1);
    raw = 1'b0;
    step(60);
    check("R2 settle", int'(lvl), 0);

    // R5: restart of the debounce window
    pol = 1'b1; sel = 4'd0;
    raw = 1'b1;
    step(10);
    raw = 1'b0;
    step(2);
    raw = 1'b1;
    step(25);                 // edge 37
    check("R5 restart not yet", int'(lvl), 0);
    step(1);                  // edge 38
    check("R5 restart accepted", int'(lvl), 1);
    raw = 1'b0;
    step(10);

    // R8: select change mid-window keeps captured length 101
    sel = 4'd2;
    raw = 1'b1;
    step(5);
    sel = 4'd0;
    step(25);                 // edge 30
    check("R8 short select ignored", int'(lvl), 0);
    step(72);                 // edge 102
    check("R8 captured length edge 102", int'(lvl), 0);
    step(1);                  // edge 103
    check("R8 captured length edge 103", int'(lvl), 1);
    raw = 1'b0;
    step(10);

    // R7: input ignored during the hold, output follows after
    mode = 1'b1; pol = 1'b1; sel = 4'd0;
    raw = 1'b1;
    step(1);
    raw = 1'b0;
    step(2);                  // edge 3
    check("R7 edge passes", int'(lvl), 1);
    step(23);                 // edge 26
    check("R7 hold masks fall", int'(lvl), 1);
    step(1);                  // edge 27
    check("R7 hold released", int'(lvl), 0);
    step(40);

    // R1: reset during activity clears output
    raw = 1'b1;
    step(3);
    rst_n = 1'b0;
    step(1);
    check("R1 reset clears", int'(lvl), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule